// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives the conversion side of a small serial codec. It owns the track/hold switch. It runs a binary search one bit at a time, from the most significant bit down. The search is paced by a self-timed internal step clock. At the end of the search it returns the sampling switch to track. A conversion begins on a start strobe from the serial front end, which the front end raises on the serial-clock falling edge that follows the last control bit. Starts are accepted only once the sampling capacitor has spent a minimum number of cycles in track. A start that comes too early is held and launched later.

For every trial the block presents a code to the capacitive array. The comparator reports whether the held input lies at or above that code's decision level. The finished code is placed in a result register, which the serial shifter sends out most significant bit first. In continuous mode the block counts serial-clock falling edges while the result is shifted out. On the edge of the last result bit it starts the next conversion on its own, so the host does not need to send a new control byte.

Top module: `sar_seq`

## Requirements
- R1: A start strobe accepted while enabled, idle and with acquisition met sets holdEn and busy at the next clock edge, and trialCode reads 0x80 (only bit 7 set) in the cycle that follows.
- R2: busy stays high for exactly 8*STEP_DIV clock cycles. busy and holdEn fall together, returning the switch to track.
- R3: Bits are decided from bit 7 down to bit 0, one every STEP_DIV cycles. A trial bit is kept when cmpHigh is 1 and cleared when it is 0, and the next lower bit is then set as the new trial.
- R4: result changes only at the edge where busy falls. At all other times it holds its value.
- R5: Leaving hold, and leaving reset or disable, clears the acquisition count. A start that arrives before ACQ_CYCLES track cycles have passed is remembered and launched at the first edge where the count is met.
- R6: With continuous mode captured at the start, the 8th sclkFall after a result is latched starts the next conversion. In single mode, sclkFall never starts a conversion.
- R7: A start strobe while idle re-captures contMode. Mode 0 ends continuous chaining. Mode 1 restarts both the conversion and the shift-out count.
- R8: With adcEnable low, start strobes are ignored and any running conversion is abandoned: busy and holdEn are low at the next edge and result is kept.
- R9: Coding is straight binary with transitions at mid-LSB. A comparator that never reports high yields 0x00, and one that always reports high yields 0xFF.
- R10: After reset, busy, holdEn, trialCode and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which also paces the internal step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startStb | input | 1 | One-cycle conversion start from the serial front end |
| contMode | input | 1 | 1 = continuous, 0 = single; captured with startStb |
| adcEnable | input | 1 | Converter powered; low aborts and blocks starts |
| sclkFall | input | 1 | One-cycle strobe on each serial-clock falling edge |
| cmpHigh | input | 1 | Comparator: held input at or above the trial level |
| trialCode | output | DATA_W | Trial code for the capacitive array |
| holdEn | output | 1 | 1 = hold, 0 = track |
| result | output | DATA_W | Last finished conversion code |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with STEP_DIV = 3 and ACQ_CYCLES = 5. A conversion is then 24 cycles, so many conversions fit in a short run. The short acquisition window lets the bench issue a start immediately after a conversion finishes and observe it being deferred. The bench models the held analog input in quarter-LSB steps, which reaches the mid-LSB transitions and both clamp codes. It also exercises chaining, re-capture of the mode and abort on disable.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Strobes from the sequencer control to the search datapath.
  typedef struct packed {
    logic launch;  // load the first trial (MSB set)
    logic decide;  // resolve the bit under test from the comparator
    logic finish;  // last decision: latch the finished code
  } sarCtl_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STEP_DIV   = 4,
  parameter int ACQ_CYCLES = 6,
  localparam int IDX_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int DIV_W     = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1,
  localparam int ACQ_W     = $clog2(ACQ_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startStb,
  input  logic             contMode,
  input  logic             adcEnable,
  input  logic             sclkFall,
  output sarCtl_t          ctl,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             holdEn
);
  localparam logic [IDX_W-1:0] LAST_SH  = IDX_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(STEP_DIV - 1);
  localparam logic [ACQ_W-1:0] ACQ_MET  = ACQ_W'(ACQ_CYCLES);

  logic [DIV_W-1:0] stepCnt;
  logic [ACQ_W-1:0] acqCnt;
  logic [IDX_W-1:0] shCnt;
  logic             pend;
  logic             contOn;

  logic acqOk, lastStep, chainReq, req, go;

  always_comb begin
    acqOk      = (acqCnt == ACQ_MET);
    lastStep   = (stepCnt == LAST_DIV);
    chainReq   = contOn && sclkFall && (shCnt == LAST_SH);
    req        = adcEnable && !busy && (startStb || chainReq);
    go         = adcEnable && !busy && (req || pend) && acqOk;
    ctl.launch = go;
    ctl.decide = adcEnable && busy && lastStep;
    ctl.finish = adcEnable && busy && lastStep && (bitIdx == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      holdEn  <= 1'b0;
      pend    <= 1'b0;
      contOn  <= 1'b0;
      shCnt   <= '0;
      acqCnt  <= '0;
      stepCnt <= '0;
      bitIdx  <= '0;
    end else if (!adcEnable) begin
      busy    <= 1'b0;
      holdEn  <= 1'b0;
      pend    <= 1'b0;
      contOn  <= 1'b0;
      shCnt   <= '0;
      acqCnt  <= '0;
      stepCnt <= '0;
    end else begin
      if (startStb && !busy) contOn <= contMode;
      if (busy) begin
        stepCnt <= lastStep ? '0 : stepCnt + 1'b1;
        if (lastStep) begin
          if (bitIdx == '0) begin
            busy   <= 1'b0;
            holdEn <= 1'b0;
            acqCnt <= '0;
            shCnt  <= '0;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
      end else if (go) begin
        busy    <= 1'b1;
        holdEn  <= 1'b1;
        pend    <= 1'b0;
        stepCnt <= '0;
        bitIdx  <= LAST_SH;
        shCnt   <= '0;
        acqCnt  <= '0;
      end else begin
        if (req) pend <= 1'b1;
        if (contOn && sclkFall) shCnt <= (shCnt == LAST_SH) ? '0 : shCnt + 1'b1;
        if (!acqOk) acqCnt <= acqCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sarCtl_t           ctl,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              cmpHigh,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] nextTrial;

  // Per-bit update: resolve the bit under test, arm the one below it.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      if (int'(bitIdx) == i)          nextTrial[i] = cmpHigh;
      else if (int'(bitIdx) == i + 1) nextTrial[i] = 1'b1;
      else                            nextTrial[i] = trialCode[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trialCode <= '0;
      result    <= '0;
    end else begin
      if (ctl.launch)      trialCode <= {1'b1, {(DATA_W-1){1'b0}}};
      else if (ctl.decide) trialCode <= nextTrial;
      if (ctl.finish)      result    <= nextTrial;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int STEP_DIV   = 4,
  parameter int ACQ_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startStb,
  input  logic              contMode,
  input  logic              adcEnable,
  input  logic              sclkFall,
  input  logic              cmpHigh,
  output logic [DATA_W-1:0] trialCode,
  output logic              holdEn,
  output logic [DATA_W-1:0] result,
  output logic              busy
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  sarCtl_t          ctl;
  logic [IDX_W-1:0] bitIdx;

  sar_ctrl #(.DATA_W(DATA_W), .STEP_DIV(STEP_DIV), .ACQ_CYCLES(ACQ_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .contMode(contMode),
    .adcEnable(adcEnable), .sclkFall(sclkFall), .ctl(ctl), .bitIdx(bitIdx),
    .busy(busy), .holdEn(holdEn)
  );

  sar_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .bitIdx(bitIdx), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .result(result)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adcEnable,
  input logic              holdEn,
  input logic              busy,
  input logic [DATA_W-1:0] trialCode,
  input logic [DATA_W-1:0] result
);
  // R1
  launch_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdEn) |-> (trialCode == {1'b1, {(DATA_W-1){1'b0}}}));

  // R2
  busy_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> holdEn);

  // R4
  result_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  // R8
  disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adcEnable |=> (!busy && !holdEn));

  // R3
  one_trial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($countones(trialCode) == 1));
endmodule

bind sar_seq sar_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .adcEnable(adcEnable), .holdEn(holdEn),
  .busy(busy), .trialCode(trialCode), .result(result)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int DIV = 3;
  localparam int ACQ = 5;
  localparam int CONV = 8 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startStb = 1'b0, contMode = 1'b0, adcEnable = 1'b1, sclkFall = 1'b0;
  logic cmpHigh;
  logic [7:0] trialCode, result;
  logic holdEn, busy;

  int ainQ = 0;    // analog input in quarter-LSB units
  int heldQ = 0;   // track/hold capacitor model
  int checks = 0, errors = 0;
  bit modelOn = 1'b0;

  // reference model state
  int mBusy, mHold, mRes, mAcq, mPend, mCont, mSh, mLeft, mCode;

  always #4 clk = ~clk;

  // comparator: decision level of code c sits at c - 1/2 LSB
  assign cmpHigh = (heldQ >= int'(trialCode) * 4 - 2);

  sar_seq #(.DATA_W(8), .STEP_DIV(DIV), .ACQ_CYCLES(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .startStb(startStb), .contMode(contMode),
    .adcEnable(adcEnable), .sclkFall(sclkFall), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .holdEn(holdEn), .result(result), .busy(busy)
  );

  function automatic int expCode(int q);
    int c;
    if (q < 0) return 0;
    c = (q + 2) / 4;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!holdEn) heldQ <= ainQ;
    if (!rst_n) begin
      mBusy = 0; mHold = 0; mRes = 0; mAcq = 0; mPend = 0;
      mCont = 0; mSh = 0; mLeft = 0; mCode = 0;
    end else if (!adcEnable) begin
      mBusy = 0; mHold = 0; mPend = 0; mCont = 0; mSh = 0; mAcq = 0;
    end else begin
      int oldCont;
      bit rq, launch;
      oldCont = mCont;
      rq = !mBusy && (startStb || (oldCont && sclkFall && mSh == 7));
      launch = !mBusy && (rq || mPend) && mAcq >= ACQ;
      if (startStb && !mBusy) mCont = contMode;
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mHold = 0; mRes = mCode; mSh = 0; mAcq = 0;
        end
      end else if (launch) begin
        mBusy = 1; mHold = 1; mLeft = CONV; mPend = 0; mSh = 0; mAcq = 0;
        mCode = expCode(ainQ);
      end else begin
        if (rq) mPend = 1;
        if (oldCont && sclkFall) mSh = (mSh + 1) % 8;
        if (mAcq < ACQ) mAcq++;
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (modelOn) begin
      chk("R2 busy vs model", busy, mBusy);
      chk("R1 holdEn vs model", holdEn, mHold);
      chk("R4 result vs model", result, mRes);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart(bit mode);
    startStb = 1'b1; contMode = mode;
    tick();
    startStb = 1'b0;
  endtask

  task automatic pulseSclk();
    sclkFall = 1'b1;
    tick();
    sclkFall = 1'b0;
    tick();
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 1000) begin tick(); guard++; end
  endtask

  task automatic convert(int q, string tag);
    ainQ = q;
    tick(ACQ + 1);
    pulseStart(1'b0);
    waitIdle();
    chk(tag, result, expCode(q));
  endtask

  task automatic runAll();
    int cnt;
    tick(2);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 holdEn", holdEn, 0);
    chk("R10 result", result, 0);
    chk("R10 trialCode", trialCode, 0);
    rst_n = 1'b1;
    modelOn = 1'b1;

    // R1 / R3 / R2 basic single conversion of code 100 (0x64)
    ainQ = 400;
    tick(ACQ + 2);
    pulseStart(1'b0);
    chk("R1 busy after start", busy, 1);
    chk("R1 first trial 0x80", trialCode, 8'h80);
    tick(DIV);
    chk("R3 bit7 cleared, bit6 armed", trialCode, 8'h40);
    tick(DIV);
    chk("R3 bit6 kept, bit5 armed", trialCode, 8'h60);
    chk("R4 result unchanged mid-conversion", result, 0);
    cnt = 2 * DIV;
    while (busy) begin tick(); cnt++; end
    chk("R2 conversion length", cnt, CONV);
    chk("R2 back to track", holdEn, 0);
    chk("R3 code 100", result, 100);

    // R9 coding corners
    convert(-8, "R9 negative input gives 0x00");
    convert(4 * 300, "R9 overrange gives 0xFF");
    convert(4 * 37 + 2, "R9 mid-LSB rounds up");
    convert(4 * 37 + 1, "R9 below mid-LSB rounds down");
    convert(4 * 255 - 2, "R9 full-scale transition");
    convert(4 * 8'h55, "R3 alternating pattern");

    // R5 early start deferred until acquisition met
    ainQ = 4 * 200;
    pulseStart(1'b0);
    cnt = 1;
    chk("R5 early start not launched", busy, 0);
    while (!busy && cnt < 50) begin tick(); cnt++; end
    chk("R5 launch after acquisition", cnt, ACQ + 1);
    waitIdle();
    chk("R5 deferred result", result, 200);

    // R6 single mode: sclk falls do not chain
    ainQ = 4 * 77;
    for (int i = 0; i < 8; i++) pulseSclk();
    tick(2);
    chk("R6 single mode no chain", busy, 0);
    chk("R6 single mode result kept", result, 200);

    // R6 continuous chaining on 8th fall
    tick(ACQ);
    pulseStart(1'b1);
    waitIdle();
    chk("R6 first continuous result", result, 77);
    ainQ = 4 * 140;
    for (int i = 0; i < 7; i++) pulseSclk();
    chk("R6 no start before 8th fall", busy, 0);
    sclkFall = 1'b1; tick(); sclkFall = 1'b0;
    chk("R6 8th fall starts conversion", busy, 1);
    waitIdle();
    chk("R6 chained result", result, 140);

    // R7 restart in continuous mode mid shift-out
    ainQ = 4 * 9;
    for (int i = 0; i < 3; i++) pulseSclk();
    pulseStart(1'b1);
    chk("R7 restart launches", busy, 1);
    waitIdle();
    chk("R7 restart result", result, 9);
    ainQ = 4 * 10;
    for (int i = 0; i < 7; i++) pulseSclk();
    chk("R7 shift count restarted", busy, 0);

    // R7 mode 0 ends chaining
    pulseStart(1'b0);
    waitIdle();
    chk("R7 single result", result, 10);
    ainQ = 4 * 11;
    for (int i = 0; i < 9; i++) pulseSclk();
    chk("R7 chain ended", busy, 0);
    chk("R7 result kept", result, 10);

    // R8 abort on disable, starts ignored while disabled
    tick(ACQ);
    pulseStart(1'b0);
    tick(4);
    adcEnable = 1'b0;
    tick();
    chk("R8 abort busy", busy, 0);
    chk("R8 abort holdEn", holdEn, 0);
    chk("R8 result kept on abort", result, 10);
    pulseStart(1'b0);
    tick(3);
    chk("R8 start ignored while disabled", busy, 0);
    adcEnable = 1'b1;
    tick(ACQ + 1);
    pulseStart(1'b0);
    chk("R8 re-enabled start", busy, 1);
    waitIdle();
    chk("R8 result after re-enable", result, 11);
    tick(3);
  endtask

  initial begin
    bit wdFired = 1'b0;
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        wdFired = 1'b1;
      end
    join_any
    modelOn = 1'b0;
    if (wdFired) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule